// File: doc/BRIEF.md
# Flash Write Protection Controller

This block guards every destructive access to a 128 KB serial flash array. A command decoder in front of it passes one decoded instruction at a time: set or clear the write-enable latch, program a page, erase a 4 KB sector, erase a 32 KB block, erase the whole chip, or rewrite the status byte. For each instruction the block answers with a one-cycle grant or deny pulse. That answer is based on the write-enable latch, a 3-bit protection field that fences off an upper part of the address space, the write-protect pin, the program length and whether a granted operation is still running.

A granted program, erase or status write marks the device busy. The array sequencer raises `op_done` when the operation finishes, and that clears both the busy flag and the write-enable latch. For a granted page program the block also reports the last byte address that will be written, with wrap-around inside the 256-byte page, and flags when a wrap happens. The status byte is always visible at the output.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 (bit 0 busy, bit 1 write-enable latch, bits 4:2 protection field, other bits zero), and neither grant nor deny is asserted.
- R2: Opcode 1 (write enable) sets the latch and opcode 2 (write disable) clears it. Each is answered with a grant one cycle after the command.
- R3: Opcodes 3 to 7 (page program, sector erase, block erase, chip erase, status write) are denied while the latch is clear, and the status byte stays unchanged.
- R4: Protection code p = 1..5 protects the addresses from 2^17 − 2^(11+p) to the top of the array (upper 1/32, 1/16, 1/8, 1/4, 1/2). Codes 6 and 7 protect everything and code 0 protects nothing. A program (its 256-byte page), sector erase or block erase whose region reaches a protected address is denied.
- R5: Chip erase (opcode 6) is granted only when the protection field is 0.
- R6: While `wp_lock` is high, a status write (opcode 7) is denied and the protection field keeps its value.
- R7: A page program with length 0 or a length above 256 is denied.
- R8: For a granted page program, `prog_last_o` becomes the page base plus ((start offset + length − 1) mod 256). `prog_wrap_o` is high when start offset + length exceeds 256.
- R9: A granted opcode 3..7 sets the busy bit. While busy, every command is denied and has no effect on the status byte.
- R10: `op_done` while busy clears the busy bit and the write-enable latch. `op_done` while idle has no effect.
- R11: A granted status write loads the protection field from bits 4:2 of `cmd_wdata`.
- R12: Every command with a non-zero opcode gets exactly one of grant or deny, one cycle later. Opcode 0 gets neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Opcode: 0 none, 1 write enable, 2 write disable, 3 page program, 4 sector erase, 5 block erase, 6 chip erase, 7 status write |
| cmd_addr | input | 17 | Target byte address |
| cmd_len | input | 9 | Program length in bytes |
| cmd_wdata | input | 8 | New status byte for a status write |
| wp_lock | input | 1 | Write-protect pin, high locks the status byte |
| op_done | input | 1 | Array sequencer reports the running operation finished |
| grant_o | output | 1 | Command accepted (one-cycle pulse) |
| deny_o | output | 1 | Command refused (one-cycle pulse) |
| status_o | output | 8 | Status byte |
| prog_last_o | output | 17 | Last byte address of the latest granted program |
| prog_wrap_o | output | 1 | Latest granted program wraps inside its page |

## Verification
The bench builds the block with its default parameters: a 17-bit address, 256-byte pages, 4 KB sectors and 32 KB blocks. With these values every protection boundary, from the top 4 KB up to the whole array, lands on a real sector edge, and the bench probes each boundary from both sides. The 9-bit length lets the bench drive lengths of 0 and 257 to test the reject path. The 8-bit page offset makes wrap and no-wrap programs at a full 256 bytes distinguishable.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_WREN   = 3'd1,
    OP_WRDI   = 3'd2,
    OP_PROG   = 3'd3,
    OP_SERASE = 3'd4,
    OP_BERASE = 3'd5,
    OP_CERASE = 3'd6,
    OP_WRSR   = 3'd7
  } wp_op_e;

  // opcodes that start a self-timed operation and need the latch
  function automatic logic op_is_write(wp_op_e op);
    return (op == OP_PROG) || (op == OP_SERASE) || (op == OP_BERASE) ||
           (op == OP_CERASE) || (op == OP_WRSR);
  endfunction

  // opcodes that modify the array and are subject to region checks
  function automatic logic op_is_array(wp_op_e op);
    return (op == OP_PROG) || (op == OP_SERASE) || (op == OP_BERASE) ||
           (op == OP_CERASE);
  endfunction

endpackage

// File: rtl/wp_region_check.sv
module wp_region_check
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int PAGE_AW = 8,
  parameter int SECT_AW = 12,
  parameter int BLK_AW  = 15,
  parameter int PROT_W  = 3,
  parameter int FRAC_N  = 5
) (
  input  wp_op_e            op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PROT_W-1:0] prot,
  output logic              hit
);
  localparam int CODES = 1 << PROT_W;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_AW) - 1);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECT_AW) - 1);
  localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((1 << BLK_AW) - 1);
  localparam logic [ADDR_W:0]   TOP_EXCL  = (ADDR_W+1)'(1) << ADDR_W;

  // lowest protected address per protection code; an extra top bit lets
  // code 0 sit above every real address
  logic [ADDR_W:0] bound_tab [CODES];

  genvar g;
  generate
    for (g = 0; g < CODES; g++) begin : g_bound
      if (g == 0) begin : g_none
        assign bound_tab[g] = TOP_EXCL;
      end else if (g <= FRAC_N) begin : g_frac
        assign bound_tab[g] = TOP_EXCL - ((ADDR_W+1)'(1) << (ADDR_W - FRAC_N - 1 + g));
      end else begin : g_all
        assign bound_tab[g] = '0;
      end
    end
  endgenerate

  logic [ADDR_W-1:0] region_end;

  always_comb begin
    unique case (op)
      OP_PROG:   region_end = addr | PAGE_MASK;
      OP_SERASE: region_end = addr | SECT_MASK;
      OP_BERASE: region_end = addr | BLK_MASK;
      OP_CERASE: region_end = '1;
      default:   region_end = addr;
    endcase
  end

  // protected range always extends to the top, so the region end decides
  assign hit = ({1'b0, region_end} >= bound_tab[prot]);

endmodule

// File: rtl/wp_page_calc.sv
module wp_page_calc #(
  parameter int ADDR_W  = 17,
  parameter int PAGE_AW = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [PAGE_AW:0]   len,
  output logic               len_ok,
  output logic [ADDR_W-1:0]  last_addr,
  output logic               wrap
);
  localparam logic [PAGE_AW:0] PAGE_BYTES = (PAGE_AW+1)'(1) << PAGE_AW;

  logic [PAGE_AW:0] end_off;

  assign len_ok    = (len != '0) && (len <= PAGE_BYTES);
  assign end_off   = {1'b0, addr[PAGE_AW-1:0]} + len - (PAGE_AW+1)'(1);
  assign wrap      = end_off[PAGE_AW];
  assign last_addr = {addr[ADDR_W-1:PAGE_AW], end_off[PAGE_AW-1:0]};

endmodule

// File: rtl/wp_state_regs.sv
module wp_state_regs #(
  parameter int                PROT_W     = 3,
  parameter logic [PROT_W-1:0] PROT_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_wel,
  input  logic              clr_wel,
  input  logic              start_op,
  input  logic              load_prot,
  input  logic [PROT_W-1:0] prot_in,
  input  logic              op_done,
  output logic              wel,
  output logic              busy,
  output logic [PROT_W-1:0] prot
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wel  <= 1'b0;
      busy <= 1'b0;
      prot <= PROT_RESET;
    end else begin
      if (busy && op_done) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else begin
        if (start_op)  busy <= 1'b1;
        if (set_wel)   wel  <= 1'b1;
        else if (clr_wel) wel <= 1'b0;
      end
      if (load_prot) prot <= prot_in;
    end
  end

  // R10: completion clears busy and the latch
  p_done_clears_r10: assert property (@(posedge clk) disable iff (rst)
    busy && op_done |=> !busy && !wel);

  // R10: a stray completion while idle leaves the latch alone
  p_idle_done_r10: assert property (@(posedge clk) disable iff (rst)
    !busy && op_done && !set_wel && !clr_wel |=> wel == $past(wel));

  // R9: while an operation runs the protection field cannot move
  p_busy_prot_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(prot));

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int PAGE_AW = 8,
  parameter int SECT_AW = 12,
  parameter int BLK_AW  = 15,
  parameter int PROT_W  = 3,
  parameter int STAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PAGE_AW:0]  cmd_len,
  input  logic [STAT_W-1:0] cmd_wdata,
  input  logic              wp_lock,
  input  logic              op_done,
  output logic              grant_o,
  output logic              deny_o,
  output logic [STAT_W-1:0] status_o,
  output logic [ADDR_W-1:0] prog_last_o,
  output logic              prog_wrap_o
);
  localparam int PROT_LSB = 2;
  localparam int PAD_W    = STAT_W - PROT_LSB - PROT_W;
  localparam logic [PAGE_AW:0] PAGE_BYTES = (PAGE_AW+1)'(1) << PAGE_AW;

  wp_op_e            op;
  logic              wel, busy;
  logic [PROT_W-1:0] prot;
  logic              hit, len_ok, wrap_c;
  logic [ADDR_W-1:0] last_c;
  logic              deny_c, grant_c;

  assign op = wp_op_e'(cmd_op);

  wp_region_check #(
    .ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .SECT_AW(SECT_AW),
    .BLK_AW(BLK_AW), .PROT_W(PROT_W)
  ) u_region (
    .op(op), .addr(cmd_addr), .prot(prot), .hit(hit)
  );

  wp_page_calc #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_page (
    .addr(cmd_addr), .len(cmd_len), .len_ok(len_ok),
    .last_addr(last_c), .wrap(wrap_c)
  );

  always_comb begin
    deny_c = busy;
    if (op_is_write(op) && !wel)         deny_c = 1'b1;
    if (op == OP_PROG && !len_ok)        deny_c = 1'b1;
    if (op_is_array(op) && hit)          deny_c = 1'b1;
    if (op == OP_WRSR && wp_lock)        deny_c = 1'b1;
  end

  assign grant_c = cmd_valid && (op != OP_NOP) && !deny_c;

  wp_state_regs #(.PROT_W(PROT_W)) u_state (
    .clk(clk), .rst(rst),
    .set_wel(grant_c && op == OP_WREN),
    .clr_wel(grant_c && op == OP_WRDI),
    .start_op(grant_c && op_is_write(op)),
    .load_prot(grant_c && op == OP_WRSR),
    .prot_in(cmd_wdata[PROT_LSB +: PROT_W]),
    .op_done(op_done),
    .wel(wel), .busy(busy), .prot(prot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o     <= 1'b0;
      deny_o      <= 1'b0;
      prog_last_o <= '0;
      prog_wrap_o <= 1'b0;
    end else begin
      grant_o <= grant_c;
      deny_o  <= cmd_valid && (op != OP_NOP) && deny_c;
      if (grant_c && op == OP_PROG) begin
        prog_last_o <= last_c;
        prog_wrap_o <= wrap_c;
      end
    end
  end

  assign status_o = {{PAD_W{1'b0}}, prot, wel, busy};

  // R3: no latch, no destructive write
  p_no_wel_deny_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && op_is_write(op) && !status_o[1] |=> deny_o && !grant_o);

  // R5: chip erase needs an empty protection field
  p_chip_erase_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && op == OP_CERASE && status_o[PROT_LSB +: PROT_W] != '0 |=> !grant_o);

  // R6: pin locks the protection field
  p_wp_lock_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && op == OP_WRSR && wp_lock |=>
      status_o[PROT_LSB +: PROT_W] == $past(status_o[PROT_LSB +: PROT_W]));

  // R7: out-of-range program lengths are refused
  p_len_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && op == OP_PROG && (cmd_len == '0 || cmd_len > PAGE_BYTES) |=> deny_o);

  // R8: the reported last address stays in the starting page
  p_same_page_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && op == OP_PROG && !status_o[0] |=>
      !grant_o || prog_last_o[ADDR_W-1:PAGE_AW] == $past(cmd_addr[ADDR_W-1:PAGE_AW]));

  // R9: everything is refused while busy
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && op != OP_NOP && status_o[0] |=> deny_o && !grant_o);

  // R12: one answer per command
  p_one_answer_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && op != OP_NOP |=> grant_o != deny_o);

endmodule

// File: tb/tb_flash_wp_ctrl.sv
module tb_flash_wp_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [16:0] cmd_addr;
  logic [8:0]  cmd_len;
  logic [7:0]  cmd_wdata;
  logic        wp_lock;
  logic        op_done;
  logic        grant_o, deny_o, prog_wrap_o;
  logic [7:0]  status_o;
  logic [16:0] prog_last_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_wp_ctrl dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
    .wp_lock(wp_lock), .op_done(op_done), .grant_o(grant_o), .deny_o(deny_o),
    .status_o(status_o), .prog_last_o(prog_last_o), .prog_wrap_o(prog_wrap_o)
  );

  // row: {op[3], addr[17], len[9], wdata[8], wp, done, exp_grant, exp_status[8]}
  localparam int NV = 36;
  localparam logic [47:0] VEC [NV] = '{
    {3'd3, 17'h00000, 9'd1,   8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 program, no latch
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h02}, // R2 set latch
    {3'd2, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h00}, // R2 clear latch
    {3'd4, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 erase, no latch
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h02},
    {3'd7, 17'h00000, 9'd0,   8'h04, 1'b1, 1'b0, 1'b0, 8'h02}, // R6 pin lock
    {3'd7, 17'h00000, 9'd0,   8'h04, 1'b0, 1'b1, 1'b1, 8'h07}, // R11 prot=1
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h06},
    {3'd3, 17'h1F000, 9'd4,   8'h00, 1'b0, 1'b0, 1'b0, 8'h06}, // R4 1/32 edge inside
    {3'd3, 17'h1EF00, 9'd256, 8'h00, 1'b0, 1'b1, 1'b1, 8'h07}, // R4 page below edge
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h06},
    {3'd6, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b0, 8'h06}, // R5 chip erase refused
    {3'd5, 17'h18000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b0, 8'h06}, // R4 top block
    {3'd4, 17'h1E000, 9'd0,   8'h00, 1'b0, 1'b1, 1'b1, 8'h07}, // R4 sector below edge
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h06},
    {3'd7, 17'h00000, 9'd0,   8'h14, 1'b0, 1'b1, 1'b1, 8'h17}, // R11 prot=5
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h16},
    {3'd4, 17'h10000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b0, 8'h16}, // R4 half edge
    {3'd4, 17'h0F000, 9'd0,   8'h00, 1'b0, 1'b1, 1'b1, 8'h17}, // R4 below half
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h16},
    {3'd7, 17'h00000, 9'd0,   8'h0C, 1'b0, 1'b1, 1'b1, 8'h0F}, // R11 prot=3
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h0E},
    {3'd4, 17'h1B000, 9'd0,   8'h00, 1'b0, 1'b1, 1'b1, 8'h0F}, // R4 below 1/8
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h0E},
    {3'd4, 17'h1C000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b0, 8'h0E}, // R4 1/8 edge
    {3'd7, 17'h00000, 9'd0,   8'h18, 1'b0, 1'b1, 1'b1, 8'h1B}, // R11 prot=6
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h1A},
    {3'd3, 17'h00000, 9'd1,   8'h00, 1'b0, 1'b0, 1'b0, 8'h1A}, // R4 whole array
    {3'd7, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b1, 1'b1, 8'h03}, // R11 prot=0
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h02},
    {3'd6, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b1, 1'b1, 8'h03}, // R5 chip erase granted
    {3'd1, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b1, 8'h02},
    {3'd3, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b0, 8'h02}, // R7 length 0
    {3'd3, 17'h00000, 9'd257, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02}, // R7 length 257
    {3'd5, 17'h18000, 9'd0,   8'h00, 1'b0, 1'b1, 1'b1, 8'h03}, // R4 no protection
    {3'd0, 17'h00000, 9'd0,   8'h00, 1'b0, 1'b0, 1'b0, 8'h00}  // R12 no-op
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one command; results are sampled on the following falling edge
  task automatic issue(input logic [2:0] op, input logic [16:0] a, input logic [8:0] len,
                       input logic [7:0] wd, input logic wp);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_len = len;
    cmd_wdata = wd; wp_lock = wp;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; wp_lock = 1'b0;
  endtask

  task automatic finish_op();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    finished = 1;
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_len = '0;
    cmd_wdata = '0; wp_lock = 1'b0; op_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 status after reset", 32'(status_o), 32'h00);
    check("R1 grant/deny after reset", {30'd0, grant_o, deny_o}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      issue(v[47:45], v[44:28], v[27:19], v[18:11], v[10]);
      if (v[47:45] == 3'd0)
        check($sformatf("R12 row %0d answers", i), {30'd0, grant_o, deny_o}, 32'd0);
      else
        check($sformatf("R12 row %0d grant/deny", i), {30'd0, grant_o, deny_o},
              {30'd0, v[8], ~v[8]});
      check($sformatf("R2/R3/R4 row %0d status", i), 32'(status_o), 32'(v[7:0]));
      if (v[9]) begin
        finish_op();
        check($sformatf("R10 row %0d status after done", i), 32'(status_o),
              32'(v[7:0] & 8'hFC));
      end
    end

    // R8 wrapping program: offset 0x05, 256 bytes -> ends at offset 0x04
    issue(3'd1, '0, '0, '0, 1'b0);
    issue(3'd3, 17'h00105, 9'd256, '0, 1'b0);
    check("R8 wrap last address", 32'(prog_last_o), 32'h00104);
    check("R8 wrap flag set", 32'(prog_wrap_o), 32'd1);
    // R9 busy: commands refused and status untouched
    check("R9 busy after grant", 32'(status_o), 32'h03);
    issue(3'd2, '0, '0, '0, 1'b0);
    check("R9 write disable refused while busy", {30'd0, grant_o, deny_o}, 32'd1);
    check("R9 status unchanged while busy", 32'(status_o), 32'h03);
    issue(3'd7, '0, '0, 8'h1C, 1'b0);
    check("R9 status write refused while busy", 32'(status_o), 32'h03);
    finish_op();
    check("R10 done clears busy and latch", 32'(status_o), 32'h00);

    // R8 aligned full page: no wrap
    issue(3'd1, '0, '0, '0, 1'b0);
    issue(3'd3, 17'h0A300, 9'd256, '0, 1'b0);
    check("R8 aligned last address", 32'(prog_last_o), 32'h0A3FF);
    check("R8 aligned no wrap", 32'(prog_wrap_o), 32'd0);
    finish_op();
    // R8 short program crossing page end: offset 0xFE, 3 bytes -> offset 0x00
    issue(3'd1, '0, '0, '0, 1'b0);
    issue(3'd3, 17'h001FE, 9'd3, '0, 1'b0);
    check("R8 short wrap last address", 32'(prog_last_o), 32'h00100);
    check("R8 short wrap flag", 32'(prog_wrap_o), 32'd1);
    finish_op();

    // R10 stray completion while idle keeps the latch
    issue(3'd1, '0, '0, '0, 1'b0);
    finish_op();
    check("R10 idle done ignored", 32'(status_o), 32'h02);

    // R1 reset mid-state clears everything
    issue(3'd7, '0, '0, 8'h10, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 status after second reset", 32'(status_o), 32'h00);

    report();
  end

endmodule